// File: doc/BRIEF.md
# Two-Tier Stream Priority Arbiter

This block decides which of several DMA stream requests gets the next access to a bus master port. Each stream presents a request bit and a 2-bit priority level written by software. The arbiter first finds the highest level among the active requests. If several streams request at that level, the stream with the smallest index wins.

The decision is registered. The arbiter samples requests and levels on one clock edge, and the chosen stream appears as a one-hot grant with a valid flag one cycle later. A grant stays in place until the granted stream pulses `access_done` to end its current single or burst access. The arbiter then arbitrates again, using the requests present in that same cycle.

A DMA engine places one instance in front of its memory-side port and one in front of its peripheral-side port. Both instances use the same rules.

Top module: `stream_prio_arb`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `grant` is all zeros and `grant_valid` is low.
- R2: If no stream requests when the arbiter is free to decide (idle, or `access_done` high), then one cycle later `grant` is all zeros and `grant_valid` is low.
- R3: The level of stream i is `stream_prio[2i+1:2i]`, coded 2'b11 very high, 2'b10 high, 2'b01 medium and 2'b00 low. A requesting stream at a higher level is always granted ahead of any requesting stream at a lower level.
- R4: Among requesting streams at the highest active level, the stream with the lowest index is granted. For example, stream 2 wins over stream 4.
- R5: A decision uses the `stream_req` and `stream_prio` values sampled at the clock edge. The resulting grant appears on the outputs after that edge, one cycle of latency.
- R6: While `grant_valid` is high and `access_done` is low, `grant` and `grant_valid` hold their values, whatever `stream_req` and `stream_prio` do.
- R7: When `grant_valid` is high and `access_done` is high, a new decision is made from the requests in that cycle. This decision may grant the same stream again.
- R8: `grant` has at most one bit set, and `grant_valid` is high exactly when one bit is set. A newly decided grant always names a stream that requested in the deciding cycle.
- R9: `access_done` has no effect while `grant_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| stream_req | input | NUM_STREAMS | One request bit per stream |
| stream_prio | input | NUM_STREAMS*PRIO_W | Packed software levels, stream i at bits [2i+1:2i] |
| access_done | input | 1 | Granted stream ends its current access |
| grant | output | NUM_STREAMS | One-hot grant, all zeros when idle |
| grant_valid | output | 1 | A stream holds the grant |

## Verification
A corrupted hold register shows at the ports as a grant that changes while `access_done` is low. This is visible in the very next cycle. A fault in the level compare or the lowest-index pick only appears when contending streams share or straddle levels, so the bench forces ties, level inversions and all-equal patterns. Any wrong decision is visible one cycle after the deciding edge. Random stimulus then compares every cycle against a bench model, so a bad grant is reported in the cycle it appears.

// File: rtl/stream_arb_pkg.sv
package stream_arb_pkg;

    localparam int unsigned NUM_STREAMS_DEF = 8;
    localparam int unsigned PRIO_W_DEF      = 2;

    typedef enum logic [1:0] {
        LVL_LOW   = 2'b00,
        LVL_MED   = 2'b01,
        LVL_HIGH  = 2'b10,
        LVL_VHIGH = 2'b11
    } level_e;

    typedef struct packed {
        logic                       valid;
        logic [NUM_STREAMS_DEF-1:0] onehot;
    } grant_s;

    // isolate the least significant set bit
    function automatic logic [NUM_STREAMS_DEF-1:0] lowest_bit(
        input logic [NUM_STREAMS_DEF-1:0] v
    );
        return v & (~v + 1'b1);
    endfunction

endpackage

// File: rtl/prio_level_select.sv
module prio_level_select #(
    parameter int unsigned NUM_STREAMS = 8,
    parameter int unsigned PRIO_W      = 2
) (
    input  logic [NUM_STREAMS-1:0]        req,
    input  logic [NUM_STREAMS*PRIO_W-1:0] prio,
    output logic [NUM_STREAMS-1:0]        cand
);
    localparam int unsigned LEVELS = 1 << PRIO_W;

    logic [NUM_STREAMS-1:0] at_level [LEVELS];
    logic [LEVELS-1:0]      level_hit;

    for (genvar lv = 0; lv < LEVELS; lv++) begin : g_lvl
        for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_str
            assign at_level[lv][s] = req[s] &&
                (prio[s*PRIO_W +: PRIO_W] == PRIO_W'(lv));
        end
        assign level_hit[lv] = |at_level[lv];
    end

    always_comb begin
        cand = '0;
        for (int lv = 0; lv < LEVELS; lv++) begin
            if (level_hit[lv]) cand = at_level[lv];
        end
    end
endmodule

// File: rtl/lowest_index_pick.sv
module lowest_index_pick #(
    parameter int unsigned NUM_STREAMS = 8
) (
    input  logic [NUM_STREAMS-1:0] cand,
    output logic [NUM_STREAMS-1:0] pick
);
    assign pick = cand & (~cand + 1'b1);
endmodule

// File: rtl/grant_hold.sv
module grant_hold #(
    parameter int unsigned NUM_STREAMS = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_STREAMS-1:0] next_pick,
    input  logic                   access_done,
    output logic [NUM_STREAMS-1:0] grant_q,
    output logic                   valid_q
);
    logic decide;
    assign decide = !valid_q || access_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            grant_q <= '0;
            valid_q <= 1'b0;
        end else if (decide) begin
            grant_q <= next_pick;
            valid_q <= |next_pick;
        end
    end
endmodule

// File: rtl/stream_prio_arb.sv
module stream_prio_arb #(
    parameter int unsigned NUM_STREAMS = 8,
    parameter int unsigned PRIO_W      = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_STREAMS-1:0]        stream_req,
    input  logic [NUM_STREAMS*PRIO_W-1:0] stream_prio,
    input  logic                          access_done,
    output logic [NUM_STREAMS-1:0]        grant,
    output logic                          grant_valid
);
    logic [NUM_STREAMS-1:0] cand;
    logic [NUM_STREAMS-1:0] pick;

    prio_level_select #(.NUM_STREAMS(NUM_STREAMS), .PRIO_W(PRIO_W)) u_level (
        .req  (stream_req),
        .prio (stream_prio),
        .cand (cand)
    );

    lowest_index_pick #(.NUM_STREAMS(NUM_STREAMS)) u_pick (
        .cand (cand),
        .pick (pick)
    );

    grant_hold #(.NUM_STREAMS(NUM_STREAMS)) u_hold (
        .clk         (clk),
        .rst         (rst),
        .next_pick   (pick),
        .access_done (access_done),
        .grant_q     (grant),
        .valid_q     (grant_valid)
    );
endmodule

// File: rtl/stream_prio_arb_checker.sv
module stream_prio_arb_checker #(
    parameter int unsigned NUM_STREAMS = 8
) (
    input logic                   clk,
    input logic                   rst,
    input logic [NUM_STREAMS-1:0] stream_req,
    input logic                   access_done,
    input logic [NUM_STREAMS-1:0] grant,
    input logic                   grant_valid
);
    // R1
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (grant == '0 && !grant_valid));

    // R8
    a_r8_onehot_valid: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant) && (grant_valid == (grant != '0)));

    // R6
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        (grant_valid && !access_done) |=> ($stable(grant) && grant_valid));

    // R2
    a_r2_idle: assert property (@(posedge clk) disable iff (rst)
        ((!grant_valid || access_done) && stream_req == '0) |=> !grant_valid);

    // R7 / R8: a fresh grant names a stream that requested
    a_r7_grant_from_req: assert property (@(posedge clk) disable iff (rst)
        (!grant_valid || access_done) |=>
            (!grant_valid || (grant & $past(stream_req)) != '0));
endmodule

bind stream_prio_arb stream_prio_arb_checker #(.NUM_STREAMS(NUM_STREAMS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .stream_req  (stream_req),
    .access_done (access_done),
    .grant       (grant),
    .grant_valid (grant_valid)
);

// File: tb/stream_prio_arb_bench.sv
`timescale 1ns/1ps
module stream_prio_arb_bench;
    localparam int N  = 8;
    localparam int PW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  req = '0;
    logic [N*PW-1:0] prio = '0;
    logic          done = 1'b0;
    logic [N-1:0]  grant;
    logic          gvalid;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    logic [N-1:0] m_grant = '0;
    logic         m_valid = 1'b0;

    always #2.5 clk = ~clk;

    stream_prio_arb #(.NUM_STREAMS(N), .PRIO_W(PW)) u_stream_prio_arb (
        .clk(clk), .rst(rst), .stream_req(req), .stream_prio(prio),
        .access_done(done), .grant(grant), .grant_valid(gvalid)
    );

    function automatic logic [N-1:0] ref_pick(input logic [N-1:0] r,
                                              input logic [N*PW-1:0] p);
        for (int lv = 3; lv >= 0; lv--) begin
            for (int s = 0; s < N; s++) begin
                if (r[s] && p[s*PW +: PW] == lv[1:0]) return N'(1) << s;
            end
        end
        return '0;
    endfunction

    task automatic check(input string tag, input logic [N-1:0] eg, input logic ev);
        checks++;
        if (grant !== eg || gvalid !== ev) begin
            fails++;
            $display("FAIL %s: grant=%b valid=%b expected grant=%b valid=%b",
                     tag, grant, gvalid, eg, ev);
        end
    endtask

    // apply inputs, advance one edge with the model, then compare
    task automatic step(input logic [N-1:0] r, input logic [N*PW-1:0] p,
                        input logic d, input string tag);
        req = r; prio = p; done = d;
        if (!m_valid || d) begin
            m_grant = ref_pick(r, p);
            m_valid = (r != '0);
        end
        @(posedge clk); #1;
        check(tag, m_grant, m_valid);
    endtask

    function automatic logic [N*PW-1:0] all_lvl(input logic [1:0] l);
        logic [N*PW-1:0] v;
        for (int s = 0; s < N; s++) v[s*PW +: PW] = l;
        return v;
    endfunction

    function automatic logic [N*PW-1:0] set_lvl(input logic [N*PW-1:0] v,
                                                input int s, input logic [1:0] l);
        logic [N*PW-1:0] t = v;
        t[s*PW +: PW] = l;
        return t;
    endfunction

    initial begin : watchdog
        #(200000 * 5);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: expired, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [N*PW-1:0] p;
        void'($urandom(32'h5eed_0042));
        req = 8'hFF; prio = all_lvl(2'b11);
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", '0, 1'b0);
        rst = 1'b0;
        req = '0;
        @(posedge clk); #1;
        check("R1 after release", '0, 1'b0);

        step('0, '0, 1'b0, "R2 no requests");
        step('0, '0, 1'b1, "R9 done while idle");

        // R4: tie at same level, stream 2 beats stream 4
        step(8'b0001_0100, all_lvl(2'b01), 1'b0, "R4 tie 2 vs 4");
        step(8'b0001_0100, all_lvl(2'b01), 1'b1, "R7 rearb same");
        // R3: higher level on higher index wins
        p = set_lvl(all_lvl(2'b00), 7, 2'b10);
        step(8'b1000_0001, p, 1'b1, "R3 high beats low");
        // R6: hold while requests and levels change
        p = set_lvl(all_lvl(2'b00), 0, 2'b11);
        step(8'b0000_0001, p, 1'b0, "R6 hold vs new very-high");
        step(8'b0000_0000, p, 1'b0, "R6 hold with req dropped");
        step(8'b0000_0011, p, 1'b1, "R7 switch after done");
        // R3 each level ordering
        p = '0;
        p = set_lvl(p, 1, 2'b00); p = set_lvl(p, 3, 2'b01);
        p = set_lvl(p, 5, 2'b10); p = set_lvl(p, 6, 2'b11);
        step(8'b0110_1010, p, 1'b1, "R3 very high wins");
        step(8'b0010_1010, p, 1'b1, "R3 high wins");
        step(8'b0000_1010, p, 1'b1, "R3 medium wins");
        step(8'b0000_0010, p, 1'b1, "R3 low alone");
        step(8'b1111_1111, all_lvl(2'b10), 1'b1, "R4 all equal");
        step(8'b1000_0000, all_lvl(2'b00), 1'b1, "R5 top index only");
        step(8'b0000_0000, all_lvl(2'b00), 1'b1, "R2 done with no req");
        step(8'b0000_0000, all_lvl(2'b00), 1'b1, "R9 done ignored idle");

        for (int i = 0; i < 3000; i++) begin
            step(N'($urandom), (N*PW)'($urandom), ($urandom % 4) == 0,
                 "R3 R4 R6 R7 R8 random");
            if (grant != '0 && (grant & (grant - 1'b1)) != '0) begin
                fails++;
                $display("FAIL R8: grant=%b expected one-hot", grant);
            end
            checks++;
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule